// File: doc/BRIEF.md
# Low-Power Run Mode Controller

This block decides when a microcontroller core may run with its voltage regulator in loose regulation, and when it must go back to full regulation. Software writes a register with two bits: a low-power request and an interrupt-wakeup enable. The request takes effect only when a set of system qualifiers allow it: slow clock mode, oscillator gain, bus speed, converter power, voltage monitor and flash activity. It also takes effect only when no debug session is active.

The regulator mode request output follows the request bit in the cycle after the write. A separate status bit reports the regulator state, and it moves only when the regulator answers with its ready signal. Three things end low-power run. Software can clear the request. A synchronized falling edge on the debug pin ends it, and this also clears the status bit at once. When wakeup is enabled, any pending interrupt ends it. A hardware exit always clears the request bit. The level of the debug pin at the first clock edge after reset is captured as the boot run-mode selection.

Top module: `lprun_ctrl`

## Requirements
- R1: A write (`reg_wr`=1) loads `wake_en_bit` from `reg_wdata_wake`. When the write has `reg_wdata_lpreq`=0, it clears `lpreq_bit` at that clock edge. When it has `reg_wdata_lpreq`=1 and entry is allowed, it sets `lpreq_bit`.
- R2: Entry is allowed only when every one of these holds: `clk_mode` equals the bypassed low-power code 3'b011, `osc_high_gain`=0, `bus_khz` < 125, `adc_low_power`=1 or `adc_enabled`=0, `lvd_enabled`=0, `flash_busy`=0.
- R3: A set write made while entry is not allowed, or while `dbg_active`=1, is ignored. A bit that was 0 stays 0.
- R4: `vreg_lp_req` equals `lpreq_bit` in every cycle, so it changes at the same edge as the mode decision.
- R5: `lp_status` changes only at an edge where `vreg_ready`=1. At that edge it takes the value `lpreq_bit` had before the edge. The one exception is the debug exit in R6. `lp_status`=0 means full regulation.
- R6: The debug pin passes through two synchronizer flops and then an edge detector. With `dbg_pin_en`=1, a high-to-low pin change made before edge E1 clears `lpreq_bit` and `lp_status` at edge E3, provided either bit is 1. With `dbg_pin_en`=0, the pin has no effect.
- R7: When `wake_en_bit`=1, `irq_pending`=1 and `lpreq_bit`=1, `lpreq_bit` clears at the next edge. `lp_status` then returns to 0 through the ready handshake.
- R8: A hardware exit (R6 or R7) that falls in the same cycle as a set write wins, and `lpreq_bit` becomes 0.
- R9: While `rst_n`=0, `lpreq_bit`, `wake_en_bit`, `lp_status` and `vreg_lp_req` are all 0.
- R10: `boot_run_sel` takes the level of `dbg_pin` at the first clock edge after reset release, then holds it until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata_lpreq | input | 1 | Written value of the low-power request |
| reg_wdata_wake | input | 1 | Written value of the interrupt-wakeup enable |
| clk_mode | input | 3 | Current clock generator mode code |
| osc_high_gain | input | 1 | Oscillator high-gain mode active |
| bus_khz | input | 16 | Bus frequency in kHz |
| adc_enabled | input | 1 | Converter enabled |
| adc_low_power | input | 1 | Converter in low-power configuration |
| lvd_enabled | input | 1 | Low-voltage detect enabled |
| flash_busy | input | 1 | Flash program or erase in progress |
| dbg_pin | input | 1 | Asynchronous debug/mode pin |
| dbg_pin_en | input | 1 | Debug pin function enabled |
| dbg_active | input | 1 | Background debug session active |
| irq_pending | input | 1 | Any interrupt pending |
| vreg_ready | input | 1 | Regulator confirms the requested mode |
| vreg_lp_req | output | 1 | Loose-regulation request to the regulator |
| lpreq_bit | output | 1 | Readback of the low-power request bit |
| wake_en_bit | output | 1 | Readback of the interrupt-wakeup enable |
| lp_status | output | 1 | Regulator status, 0 = full regulation |
| boot_run_sel | output | 1 | Debug pin level captured after reset |

## Verification
A software write that sets the request can land in the same cycle as a hardware exit. The hardware exit may be a synchronized debug-pin fall or a wakeup interrupt. Directed steps line up the pin fall two cycles ahead of the write, or hold the interrupt with the write. The long random run mixes writes, pin toggles, interrupts and ready pulses, so these collisions occur again and again. A bench model updates once per clock edge from the requirements and judges each outcome: the request bit must end up cleared, and the status must follow the ready rule.

// File: rtl/lprun_pkg.sv
package lprun_pkg;

   typedef enum logic [1:0] {
      REQ_HOLD = 2'd0,
      REQ_SET  = 2'd1,
      REQ_CLR  = 2'd2
   } req_op_e;

   typedef struct packed {
      logic clk_sel_ok;
      logic osc_ok;
      logic bus_ok;
      logic adc_ok;
      logic lvd_ok;
      logic flash_ok;
      logic dbg_ok;
   } entry_qual_t;

   function automatic logic all_qual(input entry_qual_t q);
      return &q;
   endfunction

endpackage

// File: rtl/lprun_dbgsync.sv
module lprun_dbgsync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   output logic fall_o
);
   logic [STAGES-1:0] sync_q;
   logic              prev_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("lprun_dbgsync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '1;
         prev_q <= 1'b1;
      end else begin
         sync_q <= {sync_q[STAGES-2:0], pin_i};
         prev_q <= sync_q[STAGES-1];
      end
   end

   assign fall_o = prev_q & ~sync_q[STAGES-1];

   AST_FALL_AFTER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      fall_o |-> !$past(fall_o)) else $error("double fall pulse"); // R6

endmodule

// File: rtl/lprun_gate.sv
module lprun_gate
   import lprun_pkg::*;
#(
   parameter int CLKMODE_W     = 3,
   parameter int LP_CLK_CODE   = 3,
   parameter int BUS_W         = 16,
   parameter int BUS_LIMIT_KHZ = 125
) (
   input  logic [CLKMODE_W-1:0] clk_mode_i,
   input  logic                 osc_hg_i,
   input  logic [BUS_W-1:0]     bus_khz_i,
   input  logic                 adc_en_i,
   input  logic                 adc_lp_i,
   input  logic                 lvd_en_i,
   input  logic                 flash_busy_i,
   input  logic                 dbg_active_i,
   output logic                 entry_ok_o
);
   localparam logic [CLKMODE_W-1:0] LP_CODE = CLKMODE_W'(LP_CLK_CODE);
   localparam logic [BUS_W-1:0]     LIMIT   = BUS_W'(BUS_LIMIT_KHZ);

   generate
      if (LP_CLK_CODE >= (1 << CLKMODE_W)) begin : g_bad_code
         $error("lprun_gate: LP_CLK_CODE does not fit CLKMODE_W");
      end
      if (BUS_LIMIT_KHZ >= (1 << BUS_W)) begin : g_bad_limit
         $error("lprun_gate: BUS_LIMIT_KHZ does not fit BUS_W");
      end
   endgenerate

   entry_qual_t qual;

   always_comb begin
      qual.clk_sel_ok = (clk_mode_i == LP_CODE);
      qual.osc_ok     = ~osc_hg_i;
      qual.bus_ok     = (bus_khz_i < LIMIT);
      qual.adc_ok     = adc_lp_i | ~adc_en_i;
      qual.lvd_ok     = ~lvd_en_i;
      qual.flash_ok   = ~flash_busy_i;
      qual.dbg_ok     = ~dbg_active_i;
   end

   assign entry_ok_o = all_qual(qual);

   always_comb begin
      if (dbg_active_i) AST_NO_OK_IN_DEBUG: assert (!entry_ok_o); // R3
   end

endmodule

// File: rtl/lprun_core.sv
module lprun_core
   import lprun_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic wr_i,
   input  logic wdata_req_i,
   input  logic wdata_wake_i,
   input  logic entry_ok_i,
   input  logic dbg_fall_i,
   input  logic dbg_pin_en_i,
   input  logic dbg_pin_raw_i,
   input  logic irq_i,
   input  logic ready_i,
   output logic req_o,
   output logic wake_o,
   output logic stat_o,
   output logic boot_run_o
);
   logic    req_q, wake_q, stat_q, boot_done_q, boot_run_q;
   logic    lp_active, dbg_exit, irq_exit;
   req_op_e op;
   logic    req_d, stat_d;

   assign lp_active = req_q | stat_q;
   assign dbg_exit  = dbg_pin_en_i & dbg_fall_i & lp_active;
   assign irq_exit  = wake_q & irq_i & req_q;

   always_comb begin
      if (dbg_exit || irq_exit)          op = REQ_CLR;
      else if (wr_i && !wdata_req_i)     op = REQ_CLR;
      else if (wr_i && entry_ok_i)       op = REQ_SET;
      else                               op = REQ_HOLD;
   end

   always_comb begin
      case (op)
         REQ_SET: req_d = 1'b1;
         REQ_CLR: req_d = 1'b0;
         default: req_d = req_q;
      endcase
   end

   always_comb begin
      if (dbg_exit)     stat_d = 1'b0;
      else if (ready_i) stat_d = req_q;
      else              stat_d = stat_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q       <= 1'b0;
         wake_q      <= 1'b0;
         stat_q      <= 1'b0;
         boot_done_q <= 1'b0;
         boot_run_q  <= 1'b0;
      end else begin
         req_q  <= req_d;
         stat_q <= stat_d;
         if (wr_i) wake_q <= wdata_wake_i;
         if (!boot_done_q) begin
            boot_done_q <= 1'b1;
            boot_run_q  <= dbg_pin_raw_i;
         end
      end
   end

   assign req_o      = req_q;
   assign wake_o     = wake_q;
   assign stat_o     = stat_q;
   assign boot_run_o = boot_run_q;

   AST_ENTRY_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req_q) |-> $past(entry_ok_i && wr_i && wdata_req_i)) else $error("unqualified entry"); // R3
   AST_DBG_EXIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (dbg_pin_en_i && dbg_fall_i && (req_q || stat_q)) |=> (!req_q && !stat_q)) else $error("debug exit"); // R6
   AST_IRQ_EXIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (wake_q && irq_i && req_q) |=> !req_q) else $error("irq exit"); // R7
   AST_STAT_HANDSHAKE: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_q != $past(stat_q)) |-> $past(ready_i || dbg_fall_i)) else $error("status moved"); // R5
   AST_BOOT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      $past(boot_done_q) |-> $stable(boot_run_q)) else $error("boot moved"); // R10

endmodule

// File: rtl/lprun_ctrl.sv
module lprun_ctrl #(
   parameter int SYNC_STAGES   = 2,
   parameter int CLKMODE_W     = 3,
   parameter int LP_CLK_CODE   = 3,
   parameter int BUS_W         = 16,
   parameter int BUS_LIMIT_KHZ = 125
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 reg_wr,
   input  logic                 reg_wdata_lpreq,
   input  logic                 reg_wdata_wake,
   input  logic [CLKMODE_W-1:0] clk_mode,
   input  logic                 osc_high_gain,
   input  logic [BUS_W-1:0]     bus_khz,
   input  logic                 adc_enabled,
   input  logic                 adc_low_power,
   input  logic                 lvd_enabled,
   input  logic                 flash_busy,
   input  logic                 dbg_pin,
   input  logic                 dbg_pin_en,
   input  logic                 dbg_active,
   input  logic                 irq_pending,
   input  logic                 vreg_ready,
   output logic                 vreg_lp_req,
   output logic                 lpreq_bit,
   output logic                 wake_en_bit,
   output logic                 lp_status,
   output logic                 boot_run_sel
);
   logic entry_ok, dbg_fall, req;

   lprun_gate #(
      .CLKMODE_W(CLKMODE_W), .LP_CLK_CODE(LP_CLK_CODE),
      .BUS_W(BUS_W), .BUS_LIMIT_KHZ(BUS_LIMIT_KHZ)
   ) u_gate (
      .clk_mode_i(clk_mode), .osc_hg_i(osc_high_gain), .bus_khz_i(bus_khz),
      .adc_en_i(adc_enabled), .adc_lp_i(adc_low_power), .lvd_en_i(lvd_enabled),
      .flash_busy_i(flash_busy), .dbg_active_i(dbg_active), .entry_ok_o(entry_ok)
   );

   lprun_dbgsync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .pin_i(dbg_pin), .fall_o(dbg_fall)
   );

   lprun_core u_core (
      .clk(clk), .rst_n(rst_n), .wr_i(reg_wr), .wdata_req_i(reg_wdata_lpreq),
      .wdata_wake_i(reg_wdata_wake), .entry_ok_i(entry_ok), .dbg_fall_i(dbg_fall),
      .dbg_pin_en_i(dbg_pin_en), .dbg_pin_raw_i(dbg_pin), .irq_i(irq_pending),
      .ready_i(vreg_ready), .req_o(req), .wake_o(wake_en_bit), .stat_o(lp_status),
      .boot_run_o(boot_run_sel)
   );

   assign lpreq_bit   = req;
   assign vreg_lp_req = req;

   AST_REQ_MATCHES_OUT: assert property (@(posedge clk) disable iff (!rst_n)
      vreg_lp_req == lpreq_bit) else $error("request mismatch"); // R4

endmodule

// File: tb/test_lprun_ctrl.sv
module test_lprun_ctrl;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic reg_wr = 0, reg_wdata_lpreq = 0, reg_wdata_wake = 0;
   logic [2:0]  clk_mode = 3'b011;
   logic        osc_high_gain = 0;
   logic [15:0] bus_khz = 16'd32;
   logic adc_enabled = 0, adc_low_power = 0, lvd_enabled = 0, flash_busy = 0;
   logic dbg_pin = 1, dbg_pin_en = 1, dbg_active = 0, irq_pending = 0, vreg_ready = 0;
   logic vreg_lp_req, lpreq_bit, wake_en_bit, lp_status, boot_run_sel;

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   logic m_req, m_wake, m_stat, m_boot, m_bdone, b0, b1, bp;

   always #2.5 clk = ~clk;

   lprun_ctrl i_lprun_ctrl (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata_lpreq(reg_wdata_lpreq),
      .reg_wdata_wake(reg_wdata_wake), .clk_mode(clk_mode), .osc_high_gain(osc_high_gain),
      .bus_khz(bus_khz), .adc_enabled(adc_enabled), .adc_low_power(adc_low_power),
      .lvd_enabled(lvd_enabled), .flash_busy(flash_busy), .dbg_pin(dbg_pin),
      .dbg_pin_en(dbg_pin_en), .dbg_active(dbg_active), .irq_pending(irq_pending),
      .vreg_ready(vreg_ready), .vreg_lp_req(vreg_lp_req), .lpreq_bit(lpreq_bit),
      .wake_en_bit(wake_en_bit), .lp_status(lp_status), .boot_run_sel(boot_run_sel)
   );

   function automatic logic entry_allowed();
      return (clk_mode == 3'b011) && !osc_high_gain && (bus_khz < 16'd125) &&
             (adc_low_power || !adc_enabled) && !lvd_enabled && !flash_busy && !dbg_active;
   endfunction

   task automatic check(input string tag, input string what, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
      end
   endtask

   task automatic model_reset();
      m_req = 0; m_wake = 0; m_stat = 0; m_boot = 0; m_bdone = 0;
      b0 = 1; b1 = 1; bp = 1;
   endtask

   task automatic model_edge();
      logic fall, dx, ix, nreq, nstat;
      fall = bp && !b1;
      dx   = dbg_pin_en && fall && (m_req || m_stat);
      ix   = m_wake && irq_pending && m_req;
      if (dx || ix)                        nreq = 0;
      else if (reg_wr && !reg_wdata_lpreq) nreq = 0;
      else if (reg_wr && entry_allowed())  nreq = 1;
      else                                 nreq = m_req;
      if (dx)              nstat = 0;
      else if (vreg_ready) nstat = m_req;
      else                 nstat = m_stat;
      if (reg_wr) m_wake = reg_wdata_wake;
      if (!m_bdone) begin m_bdone = 1; m_boot = dbg_pin; end
      m_req = nreq; m_stat = nstat;
      bp = b1; b1 = b0; b0 = dbg_pin;
   endtask

   task automatic step(input string tag);
      @(posedge clk);
      model_edge();
      @(negedge clk);
      check(tag, "lpreq_bit", lpreq_bit, m_req);
      check(tag, "vreg_lp_req", vreg_lp_req, m_req);
      check(tag, "wake_en_bit", wake_en_bit, m_wake);
      check(tag, "lp_status", lp_status, m_stat);
      check(tag, "boot_run_sel", boot_run_sel, m_boot);
      reg_wr = 0;
   endtask

   task automatic do_reset(input logic pin);
      @(negedge clk);
      rst_n = 0; dbg_pin = pin; reg_wr = 0; irq_pending = 0; vreg_ready = 0;
      repeat (2) @(negedge clk);
      check("R9", "lpreq_bit", lpreq_bit, 1'b0);
      check("R9", "wake_en_bit", wake_en_bit, 1'b0);
      check("R9", "lp_status", lp_status, 1'b0);
      check("R9", "vreg_lp_req", vreg_lp_req, 1'b0);
      rst_n = 1;
      model_reset();
   endtask

   task automatic wr(input logic rq, input logic wk);
      reg_wr = 1; reg_wdata_lpreq = rq; reg_wdata_wake = wk;
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      model_reset();
      void'($urandom(32'd1234));
      do_reset(1'b1);
      step("R10");
      check("R10", "boot high", boot_run_sel, 1'b1);

      // R1 R2 entry with every qualifier good, then R5 handshake
      wr(1, 0); step("R1");
      check("R4", "req out after set", vreg_lp_req, 1'b1);
      step("R5");
      check("R5", "status waits ready", lp_status, 1'b0);
      vreg_ready = 1; step("R5");
      check("R5", "status confirmed", lp_status, 1'b1);
      vreg_ready = 0;
      wr(0, 0); step("R1");
      check("R1", "clear", lpreq_bit, 1'b0);
      vreg_ready = 1; step("R5"); vreg_ready = 0;

      // R3 ignored sets
      flash_busy = 1; wr(1, 0); step("R3");
      check("R3", "flash busy blocks", lpreq_bit, 1'b0);
      flash_busy = 0; dbg_active = 1; wr(1, 0); step("R3");
      check("R3", "debug blocks", lpreq_bit, 1'b0);
      dbg_active = 0; bus_khz = 16'd125; wr(1, 0); step("R2");
      check("R2", "bus at limit blocks", lpreq_bit, 1'b0);
      bus_khz = 16'd124; adc_enabled = 1; adc_low_power = 1; wr(1, 0); step("R2");
      check("R2", "bus 124 and adc low power enter", lpreq_bit, 1'b1);

      // R6 debug pin exit
      vreg_ready = 1; step("R5"); vreg_ready = 0;
      dbg_pin = 0; step("R6"); step("R6");
      check("R6", "not yet", lpreq_bit, 1'b1);
      step("R6");
      check("R6", "req cleared", lpreq_bit, 1'b0);
      check("R6", "status cleared", lp_status, 1'b0);
      dbg_pin = 1; repeat (3) step("R6");

      // R6 disabled pin has no effect
      dbg_pin_en = 0; wr(1, 0); step("R6");
      dbg_pin = 0; repeat (4) step("R6");
      check("R6", "disabled pin ignored", lpreq_bit, 1'b1);
      dbg_pin = 1; repeat (3) step("R6"); dbg_pin_en = 1;

      // R7 interrupt wakeup
      wr(1, 1); step("R7");
      vreg_ready = 1; step("R5"); vreg_ready = 0;
      irq_pending = 1; step("R7"); irq_pending = 0;
      check("R7", "irq clears req", lpreq_bit, 1'b0);
      check("R7", "status waits", lp_status, 1'b1);
      vreg_ready = 1; step("R7"); vreg_ready = 0;
      check("R7", "status to full", lp_status, 1'b0);

      // R8 collisions
      wr(1, 1); step("R8");
      irq_pending = 1; wr(1, 1); step("R8"); irq_pending = 0;
      check("R8", "irq beats write", lpreq_bit, 1'b0);
      wr(1, 1); step("R8");
      dbg_pin = 0; step("R8"); step("R8");
      wr(1, 1); step("R8");
      check("R8", "debug fall beats write", lpreq_bit, 1'b0);
      dbg_pin = 1; repeat (3) step("R8");

      // random mix
      for (int i = 0; i < 3000; i++) begin
         reg_wr          = ($urandom_range(3) == 0);
         reg_wdata_lpreq = ($urandom_range(3) != 0);
         reg_wdata_wake  = $urandom_range(1);
         clk_mode        = ($urandom_range(7) == 0) ? 3'($urandom_range(7)) : 3'b011;
         osc_high_gain   = ($urandom_range(15) == 0);
         bus_khz         = 16'($urandom_range(140));
         adc_enabled     = $urandom_range(1);
         adc_low_power   = ($urandom_range(3) != 0);
         lvd_enabled     = ($urandom_range(15) == 0);
         flash_busy      = ($urandom_range(15) == 0);
         dbg_active      = ($urandom_range(9) == 0);
         dbg_pin_en      = ($urandom_range(3) != 0);
         if ($urandom_range(5) == 0) dbg_pin = ~dbg_pin;
         irq_pending     = ($urandom_range(9) == 0);
         vreg_ready      = $urandom_range(1);
         step("R1");
      end

      do_reset(1'b0);
      step("R10");
      check("R10", "boot low", boot_run_sel, 1'b0);
      dbg_pin = 1; repeat (2) step("R10");
      check("R10", "boot held", boot_run_sel, 1'b0);

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule